// File: doc/BRIEF.md
# Free-Slot Finder

This block tracks one occupancy flag per entry of an associative memory (4096 entries by default). A flag at 1 marks the entry empty. A flag at 0 marks the entry as holding valid contents. From the full flag vector the block keeps a registered result word that names the lowest-numbered empty entry. Entry 0 has the highest priority, so a device that is written at its next free entry fills upward from entry 0.

Write cycles and control commands can change single flags through one update port. A clear input empties every entry at once. The result word also carries the device's page number, which lets a cascade of devices tell which device answers. When no entry is empty, the block raises a full output and lowers its claim output, so the device stays out of a cascade read of the next free entry.

Top module: `free_slot_finder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties every entry. From the next edge the result word is all zero, `full` is 0 and `has_empty` is 1.
- R2: The address field of the result word holds the lowest-numbered entry whose flag is 1 (empty).
- R3: Consider an edge where `upd_valid` is 1. If `upd_empty` is 1, the flag at `upd_addr` becomes 1 (empty). If `upd_empty` is 0, that flag becomes 0 (valid). No other flag changes.
- R4: Updates presented at edge k show in the result word at edge k+1. Updates on consecutive edges each take effect.
- R5: `clear_all` at an edge sets every flag to 1 (empty). It overrides an update presented at the same edge.
- R6: When no flag is 1, `full` is 1, `has_empty` is 0 and the address field reads all ones (0xFFF). Otherwise `full` is 0 and `has_empty` is 1.
- R7: The 32-bit result word places the entry address in bits 11:0 and `page_id` (registered at the same edge) in bits 19:16. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; empties all entries |
| page_id | input | 4 | Device page number packed into the result word |
| upd_valid | input | 1 | Apply a single-flag update this edge |
| upd_addr | input | 12 | Entry whose flag is updated |
| upd_empty | input | 1 | 1 marks the entry empty, 0 marks it valid |
| clear_all | input | 1 | Mark every entry empty |
| nf_word | output | 32 | Next-free result word (address 11:0, page 19:16) |
| full | output | 1 | No entry is empty |
| has_empty | output | 1 | Device may claim the cascade read |

## Verification
The bench fills the device up to the last entry. A design that confused "last entry empty" with "full" would show the same 0xFFF address field, so the check at that point tests `full` as well as the address. The bench frees a high entry and then a low one. An encoder that favoured the highest index, or that kept a stale result, would report the wrong entry. The bench also presents a clear together with an update that marks entry 0 valid, and a design that let the update win would report entry 1. Finally it checks a reset in the middle of a run and confirms that the reserved bits of the word stay zero.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
   // Layout of the 32-bit result word
   localparam int REG_W    = 32;
   localparam int ADDR_LSB = 0;
   localparam int PAGE_LSB = 16;
   localparam int PAGE_W   = 4;
endpackage

// File: rtl/fsf_flag_store.sv
module fsf_flag_store #(
   parameter int DEPTH  = 4096,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear_all,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_empty,
   output logic [DEPTH-1:0]  flags
);
   // Flag value 1 = empty entry. Clear and reset take precedence.
   always_ff @(posedge clk) begin
      if (rst || clear_all) begin
         flags <= '1;
      end else if (upd_valid) begin
         flags[upd_addr] <= upd_empty;
      end
   end
endmodule

// File: rtl/fsf_group_enc.sv
module fsf_group_enc #(
   parameter int GRP_W = 64,
   localparam int IDX_W = $clog2(GRP_W)
) (
   input  logic [GRP_W-1:0] bits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   // Lowest set index wins: scan from the top so lower indices overwrite
   always_comb begin
      any = |bits;
      idx = '0;
      for (int i = GRP_W - 1; i >= 0; i--) begin
         if (bits[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/fsf_out_reg.sv
module fsf_out_reg #(
   parameter int ADDR_W   = 12,
   parameter int PAGE_W   = fsf_pkg::PAGE_W,
   parameter int REG_W    = fsf_pkg::REG_W,
   parameter int ADDR_LSB = fsf_pkg::ADDR_LSB,
   parameter int PAGE_LSB = fsf_pkg::PAGE_LSB
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              any_empty,
   input  logic [ADDR_W-1:0] enc_addr,
   input  logic [PAGE_W-1:0] page_id,
   output logic [REG_W-1:0]  nf_word,
   output logic              full,
   output logic              has_empty
);
   logic [ADDR_W-1:0] field_addr;
   logic [REG_W-1:0]  word_d;

   always_comb begin
      field_addr = any_empty ? enc_addr : '1;
      word_d     = '0;
      word_d[ADDR_LSB +: ADDR_W] = field_addr;
      word_d[PAGE_LSB +: PAGE_W] = page_id;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         nf_word   <= '0;
         full      <= 1'b0;
         has_empty <= 1'b1;
      end else begin
         nf_word   <= word_d;
         full      <= ~any_empty;
         has_empty <= any_empty;
      end
   end
endmodule

// File: rtl/free_slot_finder.sv
module free_slot_finder #(
   parameter int DEPTH    = 4096,
   parameter int GROUP    = 64,
   parameter int PAGE_W   = fsf_pkg::PAGE_W,
   parameter int REG_W    = fsf_pkg::REG_W,
   parameter int ADDR_LSB = fsf_pkg::ADDR_LSB,
   parameter int PAGE_LSB = fsf_pkg::PAGE_LSB,
   localparam int ADDR_W  = $clog2(DEPTH),
   localparam int NGRP    = DEPTH / GROUP,
   localparam int GIDX_W  = $clog2(GROUP),
   localparam int SEL_W   = $clog2(NGRP)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PAGE_W-1:0] page_id,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_empty,
   input  logic              clear_all,
   output logic [REG_W-1:0]  nf_word,
   output logic              full,
   output logic              has_empty
);
   // Elaboration-time parameter checks
   if ((1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (GROUP < 2 || (1 << GIDX_W) != GROUP || NGRP < 2) begin : g_bad_group
      $error("GROUP must be a power of two, at least 2, and below DEPTH");
   end
   if (ADDR_LSB + ADDR_W > PAGE_LSB || PAGE_LSB + PAGE_W > REG_W) begin : g_bad_layout
      $error("address and page fields overlap or exceed the word");
   end

   logic [DEPTH-1:0]  flags;
   logic [NGRP-1:0]   grp_any;
   logic [GIDX_W-1:0] grp_idx [NGRP];
   logic              top_any;
   logic [SEL_W-1:0]  top_sel;
   logic [ADDR_W-1:0] enc_addr;

   fsf_flag_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
      .clk       (clk),
      .rst       (rst),
      .clear_all (clear_all),
      .upd_valid (upd_valid),
      .upd_addr  (upd_addr),
      .upd_empty (upd_empty),
      .flags     (flags)
   );

   // First level: one encoder per group of flags
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      fsf_group_enc #(.GRP_W(GROUP)) u_enc (
         .bits (flags[g*GROUP +: GROUP]),
         .any  (grp_any[g]),
         .idx  (grp_idx[g])
      );
   end

   // Second level: pick the lowest group holding an empty entry
   fsf_group_enc #(.GRP_W(NGRP)) u_top (
      .bits (grp_any),
      .any  (top_any),
      .idx  (top_sel)
   );

   assign enc_addr = {top_sel, grp_idx[top_sel]};

   fsf_out_reg #(
      .ADDR_W   (ADDR_W),
      .PAGE_W   (PAGE_W),
      .REG_W    (REG_W),
      .ADDR_LSB (ADDR_LSB),
      .PAGE_LSB (PAGE_LSB)
   ) u_out (
      .clk       (clk),
      .rst       (rst),
      .any_empty (top_any),
      .enc_addr  (enc_addr),
      .page_id   (page_id),
      .nf_word   (nf_word),
      .full      (full),
      .has_empty (has_empty)
   );
endmodule

// File: rtl/fsf_checker.sv
module fsf_checker #(
   parameter int ADDR_W   = 12,
   parameter int PAGE_W   = 4,
   parameter int REG_W    = 32,
   parameter int ADDR_LSB = 0,
   parameter int PAGE_LSB = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              upd_valid,
   input logic [ADDR_W-1:0] upd_addr,
   input logic              upd_empty,
   input logic              clear_all,
   input logic [REG_W-1:0]  nf_word,
   input logic              full,
   input logic              has_empty
);
   logic [ADDR_W-1:0] w_addr;
   logic [REG_W-1:0]  used_mask;

   always_comb begin
      w_addr    = nf_word[ADDR_LSB +: ADDR_W];
      used_mask = '0;
      used_mask[ADDR_LSB +: ADDR_W] = '1;
      used_mask[PAGE_LSB +: PAGE_W] = '1;
   end

   // R1: reset leaves a clean, all-empty result
   p_reset_clean_r1: assert property (@(posedge clk)
      rst |=> (w_addr == '0 && !full && has_empty));

   // R7: bits outside the two fields stay zero
   p_word_reserved_r7: assert property (@(posedge clk) disable iff (rst)
      (nf_word & ~used_mask) == '0);

   // R6: full forces the all-ones address field
   p_full_field_r6: assert property (@(posedge clk) disable iff (rst)
      full |-> (w_addr == '1 && !has_empty));

   // R3, R2, R4: a freed entry is seen two edges later at or below its index
   p_freed_seen_r3: assert property (@(posedge clk) disable iff (rst)
      (upd_valid && upd_empty) |=> ##1 (!full && w_addr <= $past(upd_addr, 2)));

   // R5: clear empties everything, including entry 0
   p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
      clear_all |=> ##1 (w_addr == '0 && !full && has_empty));
endmodule

bind free_slot_finder fsf_checker #(
   .ADDR_W   (ADDR_W),
   .PAGE_W   (PAGE_W),
   .REG_W    (REG_W),
   .ADDR_LSB (ADDR_LSB),
   .PAGE_LSB (PAGE_LSB)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .upd_valid (upd_valid),
   .upd_addr  (upd_addr),
   .upd_empty (upd_empty),
   .clear_all (clear_all),
   .nf_word   (nf_word),
   .full      (full),
   .has_empty (has_empty)
);

// File: tb/free_slot_finder_tb_top.sv
module free_slot_finder_tb_top;
   localparam int DEPTH = 4096;
   localparam int AW    = 12;
   localparam int NV    = 14;
   // op: 1 = mark valid, 2 = mark empty
   localparam int VOP  [NV] = '{1, 1, 1, 2, 1, 1, 2, 1, 1, 1, 2, 1, 2, 1};
   localparam int VADR [NV] = '{0, 1, 2, 1, 1, 3, 0, 0, 5, 4, 2, 4095, 2, 2};
   localparam int VEXP [NV] = '{1, 2, 3, 1, 3, 4, 0, 4, 4, 6, 2, 2, 2, 6};

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [3:0]    page_id = 4'hA;
   logic          upd_valid = 1'b0;
   logic [AW-1:0] upd_addr = '0;
   logic          upd_empty = 1'b0;
   logic          clear_all = 1'b0;
   logic [31:0]   nf_word;
   logic          full;
   logic          has_empty;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   free_slot_finder dut_i (
      .clk       (clk),
      .rst       (rst),
      .page_id   (page_id),
      .upd_valid (upd_valid),
      .upd_addr  (upd_addr),
      .upd_empty (upd_empty),
      .clear_all (clear_all),
      .nf_word   (nf_word),
      .full      (full),
      .has_empty (has_empty)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // Drive one update at a negedge, drop it at the next, land on the check point
   task automatic one_op(input int op, input int adr);
      upd_valid = 1'b1;
      upd_empty = (op == 2);
      upd_addr  = AW'(adr);
      @(negedge clk);
      upd_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic expect_free(input string req, input int adr);
      chk(req, {20'h0, nf_word[11:0]}, 32'(adr));
      chk(req, {31'h0, full}, 32'h0);
      chk(req, {31'h0, has_empty}, 32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state of the registered outputs
      chk("R1 word", nf_word, 32'h0);
      chk("R1 full", {31'h0, full}, 32'h0);
      chk("R1 has_empty", {31'h0, has_empty}, 32'h1);
      @(negedge clk);
      // R7: page in 19:16, address 0, other bits zero
      chk("R7 layout", nf_word, 32'h000A_0000);

      // R2 R3 R4: vector table
      for (int i = 0; i < NV; i++) begin
         one_op(VOP[i], VADR[i]);
         expect_free($sformatf("R2/R3 vec%0d", i), VEXP[i]);
      end

      // R4: back-to-back updates on consecutive edges
      upd_valid = 1'b1; upd_empty = 1'b1; upd_addr = 12'd1;
      @(negedge clk);
      upd_empty = 1'b0; upd_addr = 12'd0;   // entry 0 already valid
      @(negedge clk);
      upd_valid = 1'b0;
      @(negedge clk);
      expect_free("R4 back-to-back", 1);

      // R5: clear beats a same-edge update that marks entry 0 valid
      clear_all = 1'b1; upd_valid = 1'b1; upd_empty = 1'b0; upd_addr = 12'd0;
      @(negedge clk);
      clear_all = 1'b0; upd_valid = 1'b0;
      @(negedge clk);
      expect_free("R5 clear wins", 0);
      one_op(1, 0);
      expect_free("R5 rest cleared", 1);

      // R6: fill all but the last entry, then the last
      for (int a = 0; a < DEPTH - 1; a++) begin
         upd_valid = 1'b1; upd_empty = 1'b0; upd_addr = AW'(a);
         @(negedge clk);
      end
      upd_valid = 1'b0;
      @(negedge clk);
      expect_free("R6 last empty", DEPTH - 1);
      one_op(1, DEPTH - 1);
      chk("R6 full word", nf_word, 32'h000A_0FFF);
      chk("R6 full", {31'h0, full}, 32'h1);
      chk("R6 has_empty", {31'h0, has_empty}, 32'h0);

      // R2: free high then low, then refill the low one
      one_op(2, 3000);
      expect_free("R2 high freed", 3000);
      one_op(2, 100);
      expect_free("R2 low wins", 100);
      one_op(1, 100);
      expect_free("R3 refill", 3000);

      // R1: reset in the middle of a run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      expect_free("R1 mid reset", 0);
      @(negedge clk);
      expect_free("R1 flags reset", 0);
      chk("R7 after reset", nf_word, 32'h000A_0000);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule